// File: doc/BRIEF.md
# Lockout Pattern Detector

This block watches a single-bit serial stream, taking one bit on every rising clock edge. It raises `found` when a one is followed directly by a zero. The pulse appears in the same cycle as that zero, because the output is decoded from the current state and the live input bit rather than taken from a register.

After a hit the detector locks out, and further one-zero pairs are ignored. It rearms only when two zeros arrive back to back. If a one arrives after only the first of those zeros, the detector falls back into the locked state and has to see two fresh zeros.

The bit is offered on every cycle with no handshake. An active-low reset, sampled on the clock edge, returns the machine to idle from any state and overrides the data bit.

Top module: `lpd_lockout_detector`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next state is idle. `found` is 0 in any cycle where `rst_n` is low.
- R2: In idle, a 0 keeps the machine in idle and a 1 moves it to the armed state. Neither raises `found`.
- R3: In the armed state, further 1s keep it armed and `found` stays 0.
- R4: `found` is 1 exactly when the machine is armed, `data` is 0 and `rst_n` is 1. This is combinational in that same cycle, and the edge ends in the locked state.
- R5: In the locked state a 1 keeps it locked. No one-zero pair raises `found` until the machine has rearmed.
- R6: In the locked state a 0 moves to the half-rearmed state. In the half-rearmed state a 1 returns to locked.
- R7: In the half-rearmed state a 0 returns to idle, after which a new one-zero pair is detected again.
- R8: Reset overrides `data` in every state, including the armed state with `data` at 0.
- R9: The input stream 0001110101101100101111 (first bit first) yields the `found` stream 0000001000000000010000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one data bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset, priority over data |
| data | input | 1 | Serial input bit |
| found | output | 1 | Combinational detect pulse on the zero of a one-zero pair |

## Verification
The hardest situation to reach is the fall-back from half-rearmed to locked. It needs a detection, then one zero, then a one, and from the ports it looks exactly like a locked machine that has seen no zero. The stimulus proves the fall-back by following it with a single zero and a one-zero pair. That pair must not be detected, while the same pair after two zeros must be. Reset priority is checked at the most sensitive point: reset is asserted while armed with `data` at 0, where `found` would otherwise be high.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ARMED  = 2'b01,
    ST_LOCKED = 2'b10,
    ST_HALF   = 2'b11
  } lpd_state_e;
endpackage

// File: rtl/lpd_next_state.sv
module lpd_next_state
  import lpd_pkg::*;
(
  input  lpd_state_e cur_state,
  input  logic       bit_in,
  output lpd_state_e nxt_state
);
  // Transition table; reset is applied in the state register.
  always_comb begin
    nxt_state = ST_IDLE;
    unique case (cur_state)
      ST_IDLE:   nxt_state = bit_in ? ST_ARMED  : ST_IDLE;
      ST_ARMED:  nxt_state = bit_in ? ST_ARMED  : ST_LOCKED;
      ST_LOCKED: nxt_state = bit_in ? ST_LOCKED : ST_HALF;
      ST_HALF:   nxt_state = bit_in ? ST_LOCKED : ST_IDLE;
      default:   nxt_state = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/lpd_output.sv
module lpd_output
  import lpd_pkg::*;
(
  input  lpd_state_e cur_state,
  input  logic       bit_in,
  input  logic       rst_n,
  output logic       hit
);
  // Mealy decode: the zero that closes a one-zero pair while armed.
  always_comb begin
    hit = 1'b0;
    if (rst_n && (cur_state == ST_ARMED) && !bit_in) hit = 1'b1;
  end
endmodule

// File: rtl/lpd_state_reg.sv
module lpd_state_reg
  import lpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lpd_state_e nxt_state,
  output lpd_state_e cur_state
);
  always_ff @(posedge clk) begin
    if (!rst_n) cur_state <= ST_IDLE;
    else        cur_state <= nxt_state;
  end
endmodule

// File: rtl/lpd_lockout_detector.sv
module lpd_lockout_detector
  import lpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic data,
  output logic found
);
  lpd_state_e state_q;
  lpd_state_e state_d;

  lpd_next_state u_next (
    .cur_state (state_q),
    .bit_in    (data),
    .nxt_state (state_d)
  );

  lpd_state_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_state (state_d),
    .cur_state (state_q)
  );

  lpd_output u_out (
    .cur_state (state_q),
    .bit_in    (data),
    .rst_n     (rst_n),
    .hit       (found)
  );
endmodule

// File: rtl/lpd_lockout_checker.sv
module lpd_lockout_checker
  import lpd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       data,
  input logic       found,
  input lpd_state_e state_q
);
  AST_RESET_TO_IDLE: assert property (@(posedge clk) !rst_n |=> (state_q == ST_IDLE)); // R1
  AST_NO_PULSE_IN_RESET: assert property (@(posedge clk) !rst_n |-> !found); // R1
  AST_IDLE_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !data) |=> (state_q == ST_IDLE)); // R2
  AST_ARMED_ONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && data) |=> (state_q == ST_ARMED)); // R3
  AST_PULSE_LEADS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> (state_q == ST_LOCKED)); // R4
  AST_SILENT_WHILE_LOCKED: assert property (@(posedge clk)
    (state_q == ST_LOCKED || state_q == ST_HALF) |-> !found); // R5
  AST_LOCK_HOLDS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED && data) |=> (state_q == ST_LOCKED)); // R5
  AST_HALF_FALLS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALF && data) |=> (state_q == ST_LOCKED)); // R6
  AST_REARM_ON_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALF && !data) |=> (state_q == ST_IDLE)); // R7
endmodule

bind lpd_lockout_detector lpd_lockout_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .data    (data),
  .found   (found),
  .state_q (state_q)
);

// File: tb/test_lpd_lockout_detector.sv
`timescale 1ns/1ps
module test_lpd_lockout_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data = 1'b0;
  logic found;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lpd_lockout_detector i_lpd_lockout_detector (
    .clk   (clk),
    .rst_n (rst_n),
    .data  (data),
    .found (found)
  );

  // Drive one cycle of inputs after a falling edge; compare found mid-cycle.
  task automatic step(input logic r, input logic d, input logic exp, input string tag);
    @(negedge clk);
    rst_n = r;
    data  = d;
    #1;
    n_cmp++;
    if (found !== exp) begin
      n_bad++;
      $display("FAIL %s: found=%b expected=%b", tag, found, exp);
    end
  endtask

  task automatic do_reset();
    step(1'b0, 1'b0, 1'b0, "R1 reset low data");
    step(1'b0, 1'b1, 1'b0, "R1 reset high data");
  endtask

  task automatic t_reset_state();
    do_reset();
    // From idle, a one then a zero must detect, proving reset left it idle.
    step(1'b1, 1'b1, 1'b0, "R1 idle after reset");
    step(1'b1, 1'b0, 1'b1, "R1 detect after reset");
  endtask

  task automatic t_idle_zeros();
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R2 idle zeros");
    step(1'b1, 1'b1, 1'b0, "R2 idle to armed");
    step(1'b1, 1'b0, 1'b1, "R2 armed then zero");
  endtask

  task automatic t_armed_ones();
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, "R3 armed ones");
    step(1'b1, 1'b0, 1'b1, "R4 pulse on zero");
    step(1'b1, 1'b1, 1'b0, "R4 single cycle pulse");
  endtask

  task automatic t_lockout();
    do_reset();
    step(1'b1, 1'b1, 1'b0, "R4 arm");
    step(1'b1, 1'b0, 1'b1, "R4 hit");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R5 locked ones");
    // Single zero then one-zero: no rearm, so no detection.
    step(1'b1, 1'b0, 1'b0, "R6 half rearm");
    step(1'b1, 1'b1, 1'b0, "R6 fall back");
    step(1'b1, 1'b0, 1'b0, "R6 half again");
    step(1'b1, 1'b1, 1'b0, "R6 fall back again");
    step(1'b1, 1'b0, 1'b0, "R5 no pulse while locked");
    step(1'b1, 1'b0, 1'b0, "R7 second zero rearms");
    step(1'b1, 1'b0, 1'b0, "R7 idle zero");
    step(1'b1, 1'b1, 1'b0, "R7 arm again");
    step(1'b1, 1'b0, 1'b1, "R7 detect after rearm");
  endtask

  task automatic t_reset_priority();
    // Armed with data 0 under reset: no pulse, and the machine is idle afterwards.
    do_reset();
    step(1'b1, 1'b1, 1'b0, "R8 arm");
    step(1'b0, 1'b0, 1'b0, "R8 reset masks pulse");
    step(1'b1, 1'b0, 1'b0, "R8 idle after armed reset");
    // Reset out of locked: a pair is then detected at once.
    step(1'b1, 1'b1, 1'b0, "R8 arm");
    step(1'b1, 1'b0, 1'b1, "R8 hit");
    step(1'b0, 1'b1, 1'b0, "R8 reset in locked");
    step(1'b1, 1'b1, 1'b0, "R8 arm after reset");
    step(1'b1, 1'b0, 1'b1, "R8 detect after locked reset");
    // Reset out of half-rearmed.
    step(1'b1, 1'b0, 1'b0, "R8 half");
    step(1'b0, 1'b1, 1'b0, "R8 reset in half");
    step(1'b1, 1'b1, 1'b0, "R8 arm after half reset");
    step(1'b1, 1'b0, 1'b1, "R8 detect after half reset");
  endtask

  task automatic t_reference();
    logic [21:0] stim = 22'b0001110101101100101111;
    logic [21:0] want = 22'b0000001000000000010000;
    do_reset();
    for (int i = 21; i >= 0; i--) step(1'b1, stim[i], want[i], "R9 reference stream");
  endtask

  initial begin
    #200000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: found=%b expected=finished", found);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_idle_zeros();
    t_armed_ones();
    t_lockout();
    t_reset_priority();
    t_reference();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule